// File: doc/BRIEF.md
# Asynchronous Memory Write Sequencer

This block turns single write requests from on-chip logic into timed write cycles on an external asynchronous memory. It runs on the bus clock. Each access drives one active-low bank select and the address. One clock later it pulls the write strobe low. The strobe stays low for the programmed number of wait states, or longer while the memory holds acknowledge low. After the strobe rises, address and write data stay driven for a programmed number of hold clocks, and then the data bus is released. A read access can also be issued. It runs the same sequence on the read strobe and never drives the data bus. Its only purpose here is to respect the turnaround gap that must follow a write. Capturing read data is not part of this block.

Requests use a valid/ready handshake. Ready is high only while the sequencer is idle and the turnaround gap for the kind of access being offered has elapsed. The wait-state count and the hold-cycle count come from two configuration inputs. Both are captured when a request is accepted. The data bus is presented as a write-data vector plus an output-enable for the pad ring.

Top module: `amw_seq`

## Requirements
- R1: After reset, all bank selects, the write strobe and the read strobe are high, the data output-enable is low, and req_ready is high.
- R2: An access drives its bank select low and the address valid from its first clock (the clock after acceptance). The strobe goes low exactly one clock later, with select and address unchanged.
- R3: With acknowledge high, the strobe stays low for exactly W clocks, where W is cfg_wait. A value of 0 gives a strobe one clock wide.
- R4: For a write, the output-enable is high and the write data is valid from the first clock of the access through the whole strobe. This is at least W+1 clocks before the strobe rises.
- R5: After the write strobe rises, the bank select goes high. Address, data and output-enable stay for exactly H clocks (H = cfg_hold). Then the output-enable goes low.
- R6: Acknowledge passes through a two-flop synchronizer and is only sampled once the W strobe clocks have elapsed. While the synchronized level is low, the strobe stays low. A low pulse on mem_ack that has cleared before the W clocks end has no effect on the strobe width.
- R7: Between two writes the write strobe stays high for at least H+1 clocks, whether or not the bank is the same. With the second request already waiting, its strobe falls exactly H+2 clocks after the first strobe rose.
- R8: After a write, the read strobe falls no earlier than H+3 clocks after the write strobe rose, with H taken from that write. With the read already waiting, it falls exactly H+3 clocks after.
- R9: A read access (req_read=1) pulses only the read strobe, for W clocks, and keeps the output-enable low. The two strobes are never low together.
- R10: cfg_wait and cfg_hold are captured at acceptance. Changing them during an access does not change that access's strobe width or hold length.
- R11: Exactly the bank select numbered req_bank goes low during an access, with bit b of mem_sel_n belonging to bank b. All others stay high.
- R12: req_ready is low from acceptance until the sequencer is idle again. A request is accepted on a clock edge where req_valid and req_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_read | input | 1 | 1 = read access, 0 = write access |
| req_bank | input | BANK_W (2) | Bank number |
| req_addr | input | ADDR_W (16) | Access address |
| req_wdata | input | DATA_W (16) | Write data |
| cfg_wait | input | WAIT_W (4) | Wait-state count W |
| cfg_hold | input | HOLD_W (4) | Hold-cycle count H |
| mem_sel_n | output | NBANK (4) | Active-low bank selects |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_addr | output | ADDR_W (16) | Memory address bus |
| mem_wdata | output | DATA_W (16) | Data toward the pad driver |
| mem_data_oe | output | 1 | Pad drive enable for the data bus |
| mem_ack | input | 1 | Memory acknowledge, asynchronous |

## Verification
Nearly every internal counter or phase error shows up at the pins within the same access. A wrong wait counter changes the measured strobe width. A wrong hold counter changes the number of clocks the output-enable outlives the strobe. A bad phase transition moves the strobe relative to the select, or makes it overlap the other strobe. Errors in the turnaround tracker surface only on the next access, as a strobe falling one or more clocks early or late against the previous write's rising edge. For that reason, back-to-back write/write and write/read pairs are measured in clocks. A synchronizer fault shows up only when acknowledge is held low past the wait window, as a width other than max(W, release+3).

// File: rtl/amw_pkg.sv
package amw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

endpackage

// File: rtl/amw_ack_sync.sv
module amw_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_raw,
    output logic ack_sync
);

    logic [STAGES-1:0] shift_d, shift_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb shift_d = ack_raw;
        end else begin : g_many
            always_comb shift_d = {shift_q[STAGES-2:0], ack_raw};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '1;
        else        shift_q <= shift_d;
    end

    assign ack_sync = shift_q[STAGES-1];

endmodule

// File: rtl/amw_gap_track.sv
module amw_gap_track #(
    parameter int HOLD_W = 4,
    localparam int SW    = HOLD_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_done,
    input  logic [HOLD_W-1:0] wr_hold,
    output logic              gap_wr_ok,
    output logic              gap_rd_ok
);

    typedef struct packed {
        logic [SW-1:0]     since;
        logic [HOLD_W-1:0] hold;
    } gap_t;

    gap_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (wr_done) begin
            g_d.since = SW'(1);
            g_d.hold  = wr_hold;
        end else if (g_q.since != '1) begin
            g_d.since = g_q.since + SW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.since <= '1;
            g_q.hold  <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign gap_wr_ok = (g_q.since >= SW'(g_q.hold));
    assign gap_rd_ok = (g_q.since >= (SW'(g_q.hold) + SW'(2)));

    // R8
    gap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !gap_rd_ok);

endmodule

// File: rtl/amw_seq.sv
module amw_seq
    import amw_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int WAIT_W = 4,
    parameter int HOLD_W = 4,
    parameter int SYNC_STAGES = 2,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_read,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [HOLD_W-1:0] cfg_hold,
    output logic [NBANK-1:0]  mem_sel_n,
    output logic              mem_we_n,
    output logic              mem_rd_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_data_oe,
    input  logic              mem_ack
);

    typedef struct packed {
        phase_e            ph;
        logic              rd;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [WAIT_W-1:0] wcnt;
        logic [HOLD_W-1:0] hlat;
        logic [HOLD_W-1:0] hcnt;
    } seq_t;

    seq_t s_d, s_q;

    logic ack_s;
    logic gap_wr_ok, gap_rd_ok;
    logic wr_done;
    logic accept;
    logic [WAIT_W-1:0] wait_eff;

    amw_ack_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_raw  (mem_ack),
        .ack_sync (ack_s)
    );

    amw_gap_track #(.HOLD_W(HOLD_W)) i_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_done   (wr_done),
        .wr_hold   (s_q.hlat),
        .gap_wr_ok (gap_wr_ok),
        .gap_rd_ok (gap_rd_ok)
    );

    assign wait_eff  = (cfg_wait == '0) ? WAIT_W'(1) : cfg_wait;
    assign req_ready = (s_q.ph == PH_IDLE) && (req_read ? gap_rd_ok : gap_wr_ok);
    assign accept    = req_valid && req_ready;

    always_comb begin
        s_d     = s_q;
        wr_done = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (accept) begin
                    s_d.ph   = PH_SETUP;
                    s_d.rd   = req_read;
                    s_d.bank = req_bank;
                    s_d.addr = req_addr;
                    s_d.data = req_wdata;
                    s_d.wcnt = wait_eff;
                    s_d.hlat = cfg_hold;
                end
            end
            PH_SETUP: begin
                s_d.ph = PH_STROBE;
            end
            PH_STROBE: begin
                if (s_q.wcnt > WAIT_W'(1)) begin
                    s_d.wcnt = s_q.wcnt - WAIT_W'(1);
                end else if (ack_s) begin
                    wr_done  = !s_q.rd;
                    s_d.hcnt = s_q.hlat;
                    s_d.ph   = (s_q.hlat != '0) ? PH_HOLD : PH_IDLE;
                end
            end
            PH_HOLD: begin
                if (s_q.hcnt > HOLD_W'(1)) s_d.hcnt = s_q.hcnt - HOLD_W'(1);
                else                       s_d.ph   = PH_IDLE;
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph   <= PH_IDLE;
            s_q.rd   <= 1'b0;
            s_q.bank <= '0;
            s_q.addr <= '0;
            s_q.data <= '0;
            s_q.wcnt <= '0;
            s_q.hlat <= '0;
            s_q.hcnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    logic sel_phase;
    assign sel_phase = (s_q.ph == PH_SETUP) || (s_q.ph == PH_STROBE);

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_sel
            assign mem_sel_n[b] = !(sel_phase && (s_q.bank == BANK_W'(b)));
        end
    endgenerate

    assign mem_we_n    = !((s_q.ph == PH_STROBE) && !s_q.rd);
    assign mem_rd_n    = !((s_q.ph == PH_STROBE) &&  s_q.rd);
    assign mem_addr    = s_q.addr;
    assign mem_wdata   = s_q.data;
    assign mem_data_oe = !s_q.rd && (s_q.ph != PH_IDLE);

    // R11
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_sel_n));

    // R2
    sel_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_we_n) || $fell(mem_rd_n)) |-> (mem_sel_n != '1) && $stable(mem_sel_n));

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_rd_n));

    // R4
    data_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_data_oe && $stable(mem_wdata));

    // R6
    strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) || $rose(mem_rd_n)) |-> $past(ack_s));

    // R12
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_sel_n == '1) && mem_we_n && mem_rd_n);

endmodule

// File: tb/test_amw_seq.sv
module test_amw_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_read = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [3:0]  cfg_wait = 4'd1;
    logic [3:0]  cfg_hold = 4'd0;
    logic [3:0]  mem_sel_n;
    logic        mem_we_n, mem_rd_n;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_data_oe;
    logic        mem_ack = 1'b1;

    amw_seq i_amw_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
        .req_bank(req_bank), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_wait(cfg_wait), .cfg_hold(cfg_hold),
        .mem_sel_n(mem_sel_n), .mem_we_n(mem_we_n), .mem_rd_n(mem_rd_n),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_data_oe(mem_data_oe),
        .mem_ack(mem_ack)
    );

    always #10 clk = ~clk;

    typedef struct {
        bit    rd;
        int    bank;
        int    addr;
        int    data;
        int    width;
        int    hold;
        int    gap;
        string wtag;
    } exp_t;

    exp_t exp_q[$];
    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_wr_rise = -1000;
    bit done = 1'b0;

    logic [3:0] prev_sel;
    logic       prev_we, prev_rd, prev_oe;

    always @(posedge clk) begin
        cyc      <= cyc + 1;
        prev_sel <= mem_sel_n;
        prev_we  <= mem_we_n;
        prev_rd  <= mem_rd_n;
        prev_oe  <= mem_data_oe;
    end

    task automatic chk(bit ok, string req, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic send(bit rd, int bank, int addr, int data, int w, int h,
                        int width, int gap, string wtag);
        exp_t e;
        e.rd = rd; e.bank = bank; e.addr = addr; e.data = data;
        e.width = width; e.hold = rd ? 0 : h; e.gap = gap; e.wtag = wtag;
        req_read  = rd;
        req_bank  = 2'(bank);
        req_addr  = 16'(addr);
        req_wdata = 16'(data);
        cfg_wait  = 4'(w);
        cfg_hold  = 4'(h);
        req_valid = 1'b1;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        exp_q.push_back(e);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic quiet();
        repeat (30) @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        exp_t e;
        bit   is_rd;
        int   width;
        int   hold;
        forever begin
            @(negedge clk);
            if (rst_n && (!mem_we_n || !mem_rd_n)) begin
                is_rd = !mem_rd_n;
                if (exp_q.size() == 0) begin
                    chk(0, "R12 unexpected access", 1, 0);
                    e.rd = is_rd; e.bank = 0; e.addr = 0; e.data = 0;
                    e.width = 0; e.hold = 0; e.gap = -1; e.wtag = "R3";
                end else begin
                    e = exp_q.pop_front();
                end
                chk(is_rd == e.rd, "R9 strobe kind", int'(is_rd), int'(e.rd));
                chk(mem_sel_n == ~(4'b0001 << e.bank), "R11 bank select",
                    int'(mem_sel_n), int'(~(4'b0001 << e.bank) & 4'hf));
                chk(prev_sel == mem_sel_n && prev_we && prev_rd,
                    "R2 select one clock ahead", int'(prev_sel), int'(mem_sel_n));
                chk(mem_addr == 16'(e.addr), "R2 address", int'(mem_addr), e.addr);
                if (!is_rd) begin
                    chk(prev_oe && mem_data_oe && mem_wdata == 16'(e.data),
                        "R4 data valid", int'(mem_wdata), e.data);
                end else begin
                    chk(!mem_data_oe, "R9 bus not driven", int'(mem_data_oe), 0);
                end
                if (e.gap >= 0)
                    chk(cyc - last_wr_rise == e.gap, is_rd ? "R8 write-read gap" : "R7 write-write gap",
                        cyc - last_wr_rise, e.gap);
                width = 0;
                while ((is_rd ? !mem_rd_n : !mem_we_n) && width < 1000) begin
                    width++;
                    @(negedge clk);
                end
                chk(width == e.width, {e.wtag, " strobe width"}, width, e.width);
                if (!is_rd) last_wr_rise = cyc;
                chk(mem_sel_n == 4'hf, "R5 select released", int'(mem_sel_n), 15);
                hold = 0;
                while (mem_data_oe && hold < 1000) begin
                    if (mem_addr != 16'(e.addr) || mem_wdata != 16'(e.data))
                        chk(0, "R5 hold stability", int'(mem_wdata), e.data);
                    hold++;
                    @(negedge clk);
                end
                chk(hold == e.hold, "R5 hold length", hold, e.hold);
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_sel_n == 4'hf && mem_we_n && mem_rd_n && !mem_data_oe,
            "R1 reset outputs", int'({mem_sel_n, mem_we_n, mem_rd_n, mem_data_oe}), 'h7e);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(req_ready, "R1 ready after reset", int'(req_ready), 1);

        // R3 R4 R5 plain write
        send(0, 0, 'h1234, 'hbeef, 3, 2, 3, -1, "R3");
        #1;
        chk(!req_ready, "R12 busy after accept", int'(req_ready), 0);
        quiet();

        // R3 zero wait, zero hold
        send(0, 3, 'h0042, 'h5a5a, 0, 0, 1, -1, "R3");
        quiet();

        // R7 back-to-back writes, different banks
        send(0, 1, 'h0100, 'h1111, 2, 3, 2, -1, "R3");
        send(0, 2, 'h0200, 'h2222, 2, 3, 2, 5, "R3");
        quiet();

        // R7 same bank, zero hold
        send(0, 2, 'h0300, 'h3333, 1, 0, 1, -1, "R3");
        send(0, 2, 'h0304, 'h4444, 1, 0, 1, 2, "R3");
        quiet();

        // R8 R9 write then waiting read
        send(0, 0, 'h0400, 'h5555, 1, 2, 1, -1, "R3");
        send(1, 1, 'h0500, 0, 2, 0, 2, 5, "R9");
        quiet();

        // R8 zero hold
        send(0, 3, 'h0600, 'h6666, 2, 0, 2, -1, "R3");
        send(1, 3, 'h0604, 0, 1, 0, 1, 3, "R9");
        quiet();

        // R10 config change mid access
        send(0, 1, 'h0700, 'h7777, 4, 1, 4, -1, "R10");
        cfg_wait = 4'd1;
        cfg_hold = 4'd9;
        quiet();

        // R6 acknowledge extension: release 4 clocks after fall -> 7
        mem_ack = 1'b0;
        repeat (4) @(negedge clk);
        send(0, 0, 'h0800, 'h8888, 2, 1, 7, -1, "R6");
        while (mem_we_n) @(negedge clk);
        repeat (4) @(negedge clk);
        mem_ack = 1'b1;
        quiet();

        // R6 short low pulse inside wait window has no effect
        send(0, 2, 'h0900, 'h9999, 3, 1, 3, -1, "R6");
        mem_ack = 1'b0;
        @(negedge clk);
        mem_ack = 1'b1;
        quiet();

        chk(exp_q.size() == 0, "R12 all requests issued", exp_q.size(), 0);
        #1;
        chk(req_ready && mem_sel_n == 4'hf, "R12 idle ready", int'(req_ready), 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule